// File: doc/BRIEF.md
# Single-Channel Peripheral-to-Memory DMA Controller

This block copies words from one peripheral data register into system memory so that the processor never has to run an interrupt routine for each arriving word. The processor first programs a source address, a destination base, a word count and a mode bit through a small write port. When the peripheral raises its request line, the controller asks the processor for the system bus. After the bus is granted, the controller acknowledges the peripheral and runs read-then-write cycles on a simple synchronous bus.

In single mode, each peripheral request moves one word to the same destination. In block mode, one request moves a counted run of words, back to back, with the bus held throughout. The source stays fixed and the destination advances by one per word. Completion of a block raises a sticky done flag. Writing the control register clears it.

Top module: `xfer_dma`

## Requirements
- R1: From idle, a high `per_req` raises `bus_req` one cycle later. `per_ack`, `bus_oe` and `bus_stb` stay low, and no memory write happens, for as long as `bus_gnt` stays low.
- R2: While `bus_gnt` is low, `bus_oe`, `bus_stb` and `bus_we` are low and `bus_addr` and `bus_wdata` are zero. Any strobe occurs only with `bus_gnt`, `bus_req` and `per_ack` all high.
- R3: After the grant, `per_ack` rises and each word takes one read cycle (`bus_stb`=1, `bus_we`=0, address = source) followed by one write cycle (`bus_we`=1) that carries the word read.
- R4: After the last write, `bus_req` and `per_ack` fall in the same cycle. No new request is accepted until both `bus_gnt` and `per_req` have been seen low.
- R5: Configuration is written with `cfg_we`, selected by `cfg_sel`: 0 = source address, 1 = destination base, 2 = word count, 3 = control, where bit 0 of the control word selects block mode (1) or single mode (0).
- R6: In single mode, each request moves exactly one word to the destination base. The destination does not advance between requests.
- R7: In block mode, one request moves `count` words. Word k goes to destination base + k, every read uses the unchanged source address, and `bus_req` stays high across the whole block.
- R8: In block mode, a count of zero moves exactly one word.
- R9: `done` goes high after the final write of a block. It does not go high in single mode. Any write to the control register clears it.
- R10: Source, destination and count are captured when the grant arrives. Configuration writes during a transfer do not change the transfer in progress.
- R11: After reset, `bus_req`, `per_ack`, `bus_oe`, `bus_stb` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | AW | Configuration write data |
| done | output | 1 | Sticky block-complete flag |
| per_req | input | 1 | Peripheral service request |
| per_ack | output | 1 | Peripheral acknowledge |
| bus_req | output | 1 | System bus request to the processor |
| bus_gnt | input | 1 | System bus grant from the processor |
| bus_oe | output | 1 | Bus output enable, high while driving |
| bus_stb | output | 1 | Bus cycle strobe |
| bus_we | output | 1 | Bus write (1) or read (0) |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data, valid in the strobe cycle |

## Verification
Most wrong internal states of this controller show up within one bus cycle. An FSM that skips the read phase produces a write strobe with no read strobe before it. A lost grant check drives the bus while the processor still owns it. A bad working counter shows up after the block, either as a sentinel overwritten past the last destination or as a missing word. A stale done flag or a handshake that drops in the wrong order shows up the cycle the bus is released, as `per_ack` and `bus_req` falling apart or a request re-accepted while the peripheral still holds `per_req`.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASK,
    ST_RD,
    ST_WR,
    ST_REL
  } dma_state_e;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          done_set,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [AW-1:0] cnt_q,
  output logic          blk_q,
  output logic          done_q
);
  logic          src_en, dst_en, cnt_en, ctl_en;
  logic          done_d;

  always_comb begin
    src_en = cfg_we && (cfg_sel == SEL_SRC);
    dst_en = cfg_we && (cfg_sel == SEL_DST);
    cnt_en = cfg_we && (cfg_sel == SEL_CNT);
    ctl_en = cfg_we && (cfg_sel == SEL_CTRL);
    done_d = done_q;
    if (ctl_en)   done_d = 1'b0;
    if (done_set) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      blk_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (src_en) src_q <= cfg_wdata;
      if (dst_en) dst_q <= cfg_wdata;
      if (cnt_en) cnt_q <= cfg_wdata;
      if (ctl_en) blk_q <= cfg_wdata[0];
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       per_req,
  input  logic       bus_gnt,
  input  logic       blk_mode,
  input  logic       last_word,
  output dma_state_e state_q,
  output logic       load,
  output logic       rd_cap,
  output logic       step,
  output logic       done_set,
  output logic       req_o,
  output logic       ack_o
);
  dma_state_e state_d;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    rd_cap   = 1'b0;
    step     = 1'b0;
    done_set = 1'b0;
    unique case (state_q)
      ST_IDLE: if (per_req) state_d = ST_ASK;
      ST_ASK: begin
        if (bus_gnt) begin
          load    = 1'b1;
          state_d = ST_RD;
        end
      end
      ST_RD: begin
        if (bus_gnt) begin
          rd_cap  = 1'b1;
          state_d = ST_WR;
        end
      end
      ST_WR: begin
        if (bus_gnt) begin
          if (blk_mode && !last_word) begin
            step    = 1'b1;
            state_d = ST_RD;
          end else begin
            done_set = blk_mode;
            state_d  = ST_REL;
          end
        end
      end
      ST_REL: if (!bus_gnt && !per_req) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign req_o = (state_q == ST_ASK) || (state_q == ST_RD) || (state_q == ST_WR);
  assign ack_o = (state_q == ST_RD) || (state_q == ST_WR);
endmodule

// File: rtl/dma_datapath.sv
module dma_datapath #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          load,
  input  logic          rd_cap,
  input  logic          step,
  input  logic [AW-1:0] src_cfg,
  input  logic [AW-1:0] dst_cfg,
  input  logic [AW-1:0] cnt_cfg,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic [DW-1:0] hold_data,
  output logic          last_word
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_src   <= '0;
      cur_dst   <= '0;
      remain_q  <= '0;
      hold_data <= '0;
    end else begin
      if (load) begin
        cur_src  <= src_cfg;
        cur_dst  <= dst_cfg;
        remain_q <= cnt_cfg;
      end else if (step) begin
        cur_dst  <= cur_dst + ONE;
        remain_q <= remain_q - ONE;
      end
      if (rd_cap) hold_data <= rdata;
    end
  end

  assign last_word = (remain_q <= ONE);
endmodule

// File: rtl/xfer_dma.sv
module xfer_dma
  import dma_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          done,
  input  logic          per_req,
  output logic          per_ack,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_oe,
  output logic          bus_stb,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);
  logic [1:0]    rst_sync_q;
  logic          rst_i;
  logic [AW-1:0] src_q, dst_q, cnt_q, cur_src, cur_dst;
  logic [DW-1:0] hold_data;
  logic          blk_q, done_set, load, rd_cap, step, last_word;
  dma_state_e    state_q;
  logic          in_rd, in_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  dma_cfg_regs #(.AW(AW)) u_cfg (
    .clk(clk), .rst_ni(rst_i), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .done_set(done_set), .src_q(src_q),
    .dst_q(dst_q), .cnt_q(cnt_q), .blk_q(blk_q), .done_q(done)
  );

  dma_fsm u_fsm (
    .clk(clk), .rst_ni(rst_i), .per_req(per_req), .bus_gnt(bus_gnt),
    .blk_mode(blk_q), .last_word(last_word), .state_q(state_q),
    .load(load), .rd_cap(rd_cap), .step(step), .done_set(done_set),
    .req_o(bus_req), .ack_o(per_ack)
  );

  dma_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_ni(rst_i), .load(load), .rd_cap(rd_cap), .step(step),
    .src_cfg(src_q), .dst_cfg(dst_q), .cnt_cfg(cnt_q), .rdata(bus_rdata),
    .cur_src(cur_src), .cur_dst(cur_dst), .hold_data(hold_data),
    .last_word(last_word)
  );

  assign in_rd = (state_q == ST_RD);
  assign in_wr = (state_q == ST_WR);

  always_comb begin
    bus_oe    = bus_gnt && (in_rd || in_wr);
    bus_stb   = bus_oe;
    bus_we    = bus_oe && in_wr;
    bus_addr  = '0;
    bus_wdata = '0;
    if (bus_oe) bus_addr = in_wr ? cur_dst : cur_src;
    if (bus_we) bus_wdata = hold_data;
  end
endmodule

// File: rtl/xfer_dma_chk.sv
module xfer_dma_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic [AW-1:0] cfg_wdata,
  input logic          done,
  input logic          per_req,
  input logic          per_ack,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_oe,
  input logic          bus_stb,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata
);
  // R1
  req_from_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(per_req));

  // R2
  strobe_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb |-> (bus_gnt && bus_req && per_ack));

  // R3
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb && bus_we) |-> $past(bus_stb && !bus_we));

  // R4
  release_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $fell(per_ack));

  // R4
  ack_drop_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(per_ack) |-> $fell(bus_req));

  // R9
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_stb && bus_we));
endmodule

bind xfer_dma xfer_dma_chk #(.AW(AW), .DW(DW)) chk_i (.*);

// File: tb/xfer_dma_tb_top.sv
module xfer_dma_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic       done, per_ack, bus_req, bus_oe, bus_stb, bus_we;
  logic       per_req = 1'b0;
  logic       bus_gnt;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;

  logic       gnt_block = 1'b0;
  logic       mem_clr = 1'b0;
  logic       per_load = 1'b0;
  logic [7:0] per_seed = 8'd0;
  logic [7:0] per_data;
  logic [7:0] cur_src = 8'd0;
  logic [7:0] mem [256];
  int         wr_cnt;
  int         n_tests = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  xfer_dma dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .done(done), .per_req(per_req), .per_ack(per_ack),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_oe(bus_oe), .bus_stb(bus_stb),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  // processor grant model: one cycle latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_gnt <= 1'b0;
    else        bus_gnt <= bus_req && !gnt_block;
  end

  assign bus_rdata = (bus_addr == cur_src) ? per_data : 8'hEE;

  // memory and peripheral data register model
  always @(posedge clk) begin
    if (mem_clr) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'hA5;
      wr_cnt <= 0;
    end else if (bus_oe && bus_stb && bus_we) begin
      mem[bus_addr] <= bus_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (per_load) per_data <= per_seed;
    else if (bus_oe && bus_stb && !bus_we) per_data <= per_data + 8'd1;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prep(input logic [7:0] src, input logic [7:0] seed);
    @(negedge clk);
    mem_clr = 1'b1; per_load = 1'b1; per_seed = seed; cur_src = src;
    @(negedge clk);
    mem_clr = 1'b0; per_load = 1'b0;
  endtask

  // raise request, wait for release, check R4 ordering, drop request
  task automatic service;
    @(negedge clk);
    per_req = 1'b1;
    while (!per_ack) @(negedge clk);
    while (bus_req) @(negedge clk);
    chk(per_ack == 1'b0, "R4 ack falls with bus_req", int'(per_ack), 0);
    per_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_words(input string tag, input logic [7:0] dst,
                             input int n, input logic [7:0] seed);
    for (int k = 0; k < n; k++)
      chk(mem[8'(dst + k)] == 8'(seed + k), tag, int'(mem[8'(dst + k)]), int'(8'(seed + k)));
    chk(mem[8'(dst + n)] == 8'hA5, {tag, " sentinel"}, int'(mem[8'(dst + n)]), 'hA5);
    chk(wr_cnt == n, {tag, " write count"}, wr_cnt, n);
  endtask

  // {mode, src, dst, count, seed}
  localparam logic [39:0] VEC [5] = '{
    {8'd0, 8'hF0, 8'h10, 8'd0, 8'h30},
    {8'd1, 8'hF1, 8'h20, 8'd4, 8'h40},
    {8'd1, 8'hF2, 8'h40, 8'd1, 8'h55},
    {8'd1, 8'hF3, 8'h50, 8'd0, 8'h66},
    {8'd1, 8'hF4, 8'h60, 8'd9, 8'h70}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(!bus_req && !per_ack && !bus_oe && !bus_stb && !done, "R11 reset outputs",
        int'({bus_req, per_ack, bus_oe, bus_stb, done}), 0);

    // table walk: R5 encodings, R3 read/write, R6 single, R7 block, R8 zero count
    for (int v = 0; v < 5; v++) begin
      logic [7:0] md, sr, ds, ct, sd;
      int n;
      string tag;
      {md, sr, ds, ct, sd} = VEC[v];
      n = (md[0] == 1'b0) ? 1 : ((ct == 8'd0) ? 1 : int'(ct));
      tag = (md[0] == 1'b0) ? "R6 single word" : ((ct == 8'd0) ? "R8 zero count" : "R7 block word");
      prep(sr, sd);
      cfg_write(2'd0, sr);
      cfg_write(2'd1, ds);
      cfg_write(2'd2, ct);
      cfg_write(2'd3, md);
      chk(done == 1'b0, "R9 cleared by control write", int'(done), 0);
      service();
      check_words({tag, " R3"}, ds, n, sd);
      chk(done == md[0], "R9 done after block only", int'(done), int'(md[0]));
    end

    // R6: second single request writes the same destination, next data
    prep(8'hE0, 8'h11);
    cfg_write(2'd0, 8'hE0);
    cfg_write(2'd1, 8'h80);
    cfg_write(2'd3, 8'd0);
    service();
    service();
    chk(mem[8'h80] == 8'h12, "R6 same destination", int'(mem[8'h80]), 'h12);
    chk(mem[8'h81] == 8'hA5, "R6 no advance", int'(mem[8'h81]), 'hA5);
    chk(wr_cnt == 2, "R6 one word per request", wr_cnt, 2);

    // R1/R2: no bus activity without grant
    prep(8'hE0, 8'h20);
    gnt_block = 1'b1;
    @(negedge clk);
    per_req = 1'b1;
    @(negedge clk);
    chk(bus_req == 1'b1, "R1 bus_req after one cycle", int'(bus_req), 1);
    repeat (5) @(negedge clk);
    chk(!per_ack && !bus_oe && !bus_stb, "R1 idle until grant",
        int'({per_ack, bus_oe, bus_stb}), 0);
    chk(bus_addr == 8'd0 && bus_wdata == 8'd0 && !bus_we, "R2 bus quiet without grant",
        int'(bus_addr), 0);
    chk(wr_cnt == 0, "R1 no write before grant", wr_cnt, 0);
    gnt_block = 1'b0;
    while (bus_req) @(negedge clk);
    // R4: request still high after release is not re-accepted
    repeat (4) @(negedge clk);
    chk(bus_req == 1'b0, "R4 no re-accept while per_req high", int'(bus_req), 0);
    per_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(wr_cnt == 1, "R4 exactly one transfer", wr_cnt, 1);

    // R10: config rewrite mid-block does not disturb the block
    prep(8'hE4, 8'h90);
    cfg_write(2'd0, 8'hE4);
    cfg_write(2'd1, 8'hA0);
    cfg_write(2'd2, 8'd6);
    cfg_write(2'd3, 8'd1);
    @(negedge clk);
    per_req = 1'b1;
    while (!per_ack) @(negedge clk);
    cfg_write(2'd1, 8'hC0);
    cfg_write(2'd2, 8'd2);
    while (bus_req) @(negedge clk);
    per_req = 1'b0;
    repeat (3) @(negedge clk);
    check_words("R10 block unaffected", 8'hA0, 6, 8'h90);
    chk(mem[8'hC0] == 8'hA5, "R10 new base untouched", int'(mem[8'hC0]), 'hA5);
    chk(done == 1'b1, "R9 done set", int'(done), 1);
    cfg_write(2'd3, 8'd1);
    chk(done == 1'b0, "R9 done cleared by control write", int'(done), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule